// File: doc/BRIEF.md
# Priority Interrupt Level Arbiter

This block decides which interrupt level, if any, is offered to a processor core. Sixteen level-sensitive external lines and a software interrupt register form a pending vector. The block compares that vector with the core's interrupt mask level, its global interrupt enable and its current trap state. It then drives a registered request flag and a registered trap type code. A separate one-cycle wake pulse tells the core to leave a halted state when an external line rises.

The decision is held in a two-state machine. In `ST_IDLE` no request is offered and the trap type is zero. In `ST_ACTIVE` a request is offered with a nonzero trap type. Each cycle a decision is taken. `DEC_RAISE` moves to `ST_ACTIVE`, or changes the level while already in `ST_ACTIVE`. `DEC_WITHDRAW` returns to `ST_IDLE` and clears the trap type. `DEC_HOLD` keeps both the state and the trap type. The transitions are IDLE→ACTIVE (raise), ACTIVE→ACTIVE (retarget to a new level), ACTIVE→IDLE (withdraw), and a hold loop in each state.

Top module: `pil_arbiter`

## Requirements
- R1: Level L (1..15) is pending when external line L or software bit L is high. Level 0 is pending only from external line 0. Software bit 0 is the tick-match bit and bit 16 is the system-tick-match bit; neither makes a level of its own.
- R2: When either timer-match bit (software bit 0 or bit 16) is set, level 14 is pending.
- R3: When no pending level lies strictly above `mask_lvl`, the request drops and `irq_tt` becomes zero on the next clock, whatever the enable and trap inputs are.
- R4: When enabled, the highest pending level above the mask wins. `irq_tt` is 0x040 OR'ed with the level number (bits 3:0 = level, bits 8:4 = 0x04).
- R5: When `trap_lvl` is nonzero and `cur_tt` is numerically greater than the new trap type, the outputs keep their previous values. When `trap_lvl` is zero, `cur_tt` has no effect, and an equal `cur_tt` does not block.
- R6: While `int_en` is low, no request is raised, and an outstanding request is withdrawn with `irq_tt` cleared on the next clock.
- R7: A rising external line gives `wake` high for exactly the one cycle after the edge. A falling line gives no wake pulse.
- R8: Reset (active-low, asynchronous) clears `irq_req`, `irq_tt` and `wake`.
- R9: `irq_req` and `irq_tt` are registered. They change only at a clock edge, one clock after the input change that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_lines | input | 16 | Level-sensitive external interrupt lines, bit = level |
| soft_reg | input | 17 | Software interrupt register; bit 0 tick match, bit 16 system-tick match |
| mask_lvl | input | 4 | Processor interrupt mask level |
| int_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap nesting level |
| cur_tt | input | 9 | Trap type currently being serviced |
| irq_req | output | 1 | Interrupt request to the core |
| irq_tt | output | 9 | Trap type of the offered interrupt, zero when idle |
| wake | output | 1 | One-cycle pulse that clears a halted state |

## Verification
A wrong state register shows at the ports within one clock: a stuck `ST_ACTIVE` keeps `irq_req` high with a stale or zero trap type, and a stuck `ST_IDLE` never raises a request. A corrupted trap type register shows either as a level at or below the mask that appears on a change, or as a code outside 0x041–0x04F. The bench model predicts `irq_req`, `irq_tt` and `wake` for every cycle, so any divergence is reported in the cycle it first appears.

// File: rtl/pil_pkg.sv
package pil_pkg;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } arb_state_e;

    typedef enum logic [1:0] {
        DEC_HOLD     = 2'd0,
        DEC_RAISE    = 2'd1,
        DEC_WITHDRAW = 2'd2
    } arb_dec_e;

endpackage

// File: rtl/pil_pending.sv
module pil_pending #(
    parameter int NLVL      = 16,
    parameter int TIMER_LVL = 14
) (
    input  logic [NLVL-1:0] ext_lines,
    input  logic [NLVL:0]   soft_reg,
    output logic [NLVL-1:0] pend
);
    // soft_reg[0] and soft_reg[NLVL] are the timer-match bits
    logic timer_hit;
    assign timer_hit = soft_reg[0] | soft_reg[NLVL];

    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
        if (l == 0) begin : g_zero
            assign pend[l] = ext_lines[l];
        end else if (l == TIMER_LVL) begin : g_timer
            assign pend[l] = ext_lines[l] | soft_reg[l] | timer_hit;
        end else begin : g_plain
            assign pend[l] = ext_lines[l] | soft_reg[l];
        end
    end
endmodule

// File: rtl/pil_select.sv
module pil_select #(
    parameter int NLVL = 16,
    localparam int LW  = $clog2(NLVL)
) (
    input  logic [NLVL-1:0] pend,
    input  logic [LW-1:0]   mask_lvl,
    output logic            above,
    output logic [LW-1:0]   win_lvl
);
    logic [NLVL+1:0] thresh;

    // pending vector must reach 2 << mask to have a bit above the mask
    assign thresh = {{NLVL{1'b0}}, 2'b10} << mask_lvl;
    assign above  = {2'b00, pend} >= thresh;

    // ascending scan, last hit wins: highest level above the mask
    always_comb begin
        win_lvl = '0;
        for (int l = 1; l < NLVL; l++) begin
            if (pend[l] && (LW'(l) > mask_lvl)) begin
                win_lvl = LW'(l);
            end
        end
    end
endmodule

// File: rtl/pil_edge.sv
module pil_edge #(
    parameter int NLVL = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NLVL-1:0] ext_lines,
    output logic            wake
);
    logic [NLVL-1:0] lines_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lines_q <= '0;
            wake    <= 1'b0;
        end else begin
            lines_q <= ext_lines;
            wake    <= |(ext_lines & ~lines_q);
        end
    end
endmodule

// File: rtl/pil_arbiter.sv
module pil_arbiter
    import pil_pkg::*;
#(
    parameter int            NLVL      = 16,
    parameter int            TT_W      = 9,
    parameter int            TL_W      = 3,
    parameter int            TIMER_LVL = 14,
    parameter logic [8:0]    TT_BASE   = 9'h040,
    localparam int           LW        = $clog2(NLVL)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NLVL-1:0] ext_lines,
    input  logic [NLVL:0]   soft_reg,
    input  logic [LW-1:0]   mask_lvl,
    input  logic            int_en,
    input  logic [TL_W-1:0] trap_lvl,
    input  logic [TT_W-1:0] cur_tt,
    output logic            irq_req,
    output logic [TT_W-1:0] irq_tt,
    output logic            wake
);
    logic [NLVL-1:0] pend;
    logic            above;
    logic [LW-1:0]   win_lvl;
    logic [TT_W-1:0] new_tt;
    logic [TT_W-1:0] tt_q;
    arb_state_e      state_q, state_d;
    arb_dec_e        dec;

    pil_pending #(.NLVL(NLVL), .TIMER_LVL(TIMER_LVL)) u_pend (
        .ext_lines (ext_lines),
        .soft_reg  (soft_reg),
        .pend      (pend)
    );

    pil_select #(.NLVL(NLVL)) u_sel (
        .pend     (pend),
        .mask_lvl (mask_lvl),
        .above    (above),
        .win_lvl  (win_lvl)
    );

    pil_edge #(.NLVL(NLVL)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_lines (ext_lines),
        .wake      (wake)
    );

    assign new_tt = TT_W'(TT_BASE) | TT_W'(win_lvl);

    // decision
    always_comb begin
        if (!above) begin
            dec = DEC_WITHDRAW;
        end else if (!int_en) begin
            dec = (state_q == ST_ACTIVE) ? DEC_WITHDRAW : DEC_HOLD;
        end else if ((trap_lvl != '0) && (cur_tt > new_tt)) begin
            dec = DEC_HOLD;
        end else if (new_tt != tt_q) begin
            dec = DEC_RAISE;
        end else begin
            dec = DEC_HOLD;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (dec == DEC_RAISE) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (dec == DEC_WITHDRAW) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tt_q <= '0;
        end else begin
            unique case (dec)
                DEC_RAISE:    tt_q <= new_tt;
                DEC_WITHDRAW: tt_q <= '0;
                default:      tt_q <= tt_q;
            endcase
        end
    end

    assign irq_req = (state_q == ST_ACTIVE);
    assign irq_tt  = tt_q;
endmodule

// File: rtl/pil_arbiter_chk.sv
module pil_arbiter_chk #(
    parameter int         NLVL    = 16,
    parameter int         TT_W    = 9,
    parameter int         TL_W    = 3,
    parameter logic [8:0] TT_BASE = 9'h040,
    localparam int        LW      = $clog2(NLVL)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NLVL-1:0] ext_lines,
    input logic [LW-1:0]   mask_lvl,
    input logic            int_en,
    input logic [TL_W-1:0] trap_lvl,
    input logic [TT_W-1:0] cur_tt,
    input logic            irq_req,
    input logic [TT_W-1:0] irq_tt,
    input logic            wake
);
    localparam logic [TT_W-1:0] TT_TOP = TT_W'(TT_BASE) | TT_W'(NLVL - 1);

    AST_IDLE_TT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_tt == '0)); // R3

    AST_TT_ENCODING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((irq_tt >> LW) == (TT_W'(TT_BASE) >> LW)) && (irq_tt[LW-1:0] != '0)); // R4

    AST_NEW_LEVEL_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && (irq_tt != $past(irq_tt))) |-> (irq_tt[LW-1:0] > $past(mask_lvl))); // R4

    AST_TOP_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_lvl == LW'(NLVL - 1)) |=> !irq_req); // R3

    AST_DISABLED_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |=> !irq_req); // R6

    AST_TRAP_BLOCKS_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        ((trap_lvl != '0) && (cur_tt > TT_TOP) && !irq_req) |=> !irq_req); // R5

    AST_NO_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_lines == '0) |=> !wake); // R7
endmodule

bind pil_arbiter pil_arbiter_chk #(
    .NLVL(NLVL), .TT_W(TT_W), .TL_W(TL_W), .TT_BASE(TT_BASE)
) u_pil_chk (
    .clk(clk), .rst_n(rst_n), .ext_lines(ext_lines), .mask_lvl(mask_lvl),
    .int_en(int_en), .trap_lvl(trap_lvl), .cur_tt(cur_tt),
    .irq_req(irq_req), .irq_tt(irq_tt), .wake(wake)
);

// File: tb/test_pil_arbiter.sv
`timescale 1ns/1ps
module test_pil_arbiter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] ext_lines;
    logic [16:0] soft_reg;
    logic [3:0]  mask_lvl;
    logic        int_en;
    logic [2:0]  trap_lvl;
    logic [8:0]  cur_tt;
    logic        irq_req;
    logic [8:0]  irq_tt;
    logic        wake;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pil_arbiter i_pil_arbiter (
        .clk(clk), .rst_n(rst_n), .ext_lines(ext_lines), .soft_reg(soft_reg),
        .mask_lvl(mask_lvl), .int_en(int_en), .trap_lvl(trap_lvl), .cur_tt(cur_tt),
        .irq_req(irq_req), .irq_tt(irq_tt), .wake(wake)
    );

    // behavioural reference model
    bit m_req;
    int m_tt;
    bit m_wake;
    int m_prev;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_req = 0; m_tt = 0; m_wake = 0; m_prev = 0;
        end else begin
            int pv, win, ntt;
            pv = 0;
            for (int l = 0; l < 16; l++) begin
                if (ext_lines[l] || (l > 0 && soft_reg[l])) pv = pv | (1 << l);
            end
            if (soft_reg[0] || soft_reg[16]) pv = pv | (1 << 14);
            win = 0;
            for (int l = 15; l > int'(mask_lvl); l--) begin
                if (pv[l]) begin win = l; break; end
            end
            ntt = 'h40 | win;
            if (pv < (2 << mask_lvl)) begin
                m_req = 0; m_tt = 0;
            end else if (!int_en) begin
                if (m_req) begin m_req = 0; m_tt = 0; end
            end else if (trap_lvl != 0 && int'(cur_tt) > ntt) begin
                // held
            end else if (ntt != m_tt) begin
                m_req = 1; m_tt = ntt;
            end
            m_wake = ((int'(ext_lines) & ~m_prev) != 0);
            m_prev = int'(ext_lines);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // cycle compare against the model (R4 R5 R6 R9)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(irq_req == m_req, "R9 model req", irq_req, m_req);
            chk(int'(irq_tt) == m_tt, "R4 model tt", irq_tt, m_tt);
            chk(wake == m_wake, "R7 model wake", wake, m_wake);
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic expect_out(input bit req, input int tt, input string tag);
        chk(irq_req == req, tag, irq_req, req);
        chk(int'(irq_tt) == tt, tag, irq_tt, tt);
    endtask

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; ext_lines = 0; soft_reg = 0; mask_lvl = 0;
        int_en = 1; trap_lvl = 0; cur_tt = 0;
        repeat (3) step();
        expect_out(0, 0, "R8 reset");
        chk(wake == 0, "R8 reset wake", wake, 0);
        rst_n = 1;
        step();

        // R4 single line, R7 wake, R9 latency
        ext_lines = 16'h0020;
        #1 chk(irq_req == 0, "R9 no change before edge", irq_req, 0);
        step();
        expect_out(1, 'h45, "R4 level5");
        chk(wake == 1, "R7 rise wake", wake, 1);
        step();
        chk(wake == 0, "R7 wake one cycle", wake, 0);

        // R4 highest wins
        ext_lines = 16'h0220; step();
        expect_out(1, 'h49, "R4 level9 wins");

        // R3 mask equal to top pending
        mask_lvl = 9; step();
        expect_out(0, 0, "R3 masked");
        mask_lvl = 8; step();
        expect_out(1, 'h49, "R3 unmasked");

        // R7 falling line gives no wake
        ext_lines = 16'h0000; step();
        chk(wake == 0, "R7 fall no wake", wake, 0);
        expect_out(0, 0, "R3 nothing pending");

        // R2 timer bits
        mask_lvl = 0; soft_reg = 17'h00001; step();
        expect_out(1, 'h4E, "R2 tick");
        soft_reg = 17'h10000; step(); step();
        expect_out(1, 'h4E, "R2 stick");
        mask_lvl = 14; step();
        expect_out(0, 0, "R3 timer masked");

        // R1 software level
        mask_lvl = 0; soft_reg = 17'h00008; step();
        expect_out(1, 'h43, "R1 soft level3");

        // R5 trap blocking
        trap_lvl = 1; cur_tt = 9'h060; ext_lines = 16'h0400; step(); step();
        expect_out(1, 'h43, "R5 blocked hold");
        trap_lvl = 0; step();
        expect_out(1, 'h4A, "R5 trap level zero");
        trap_lvl = 1; cur_tt = 9'h04B; ext_lines = 16'h1000; step();
        expect_out(1, 'h4C, "R5 lower cur_tt");
        cur_tt = 9'h04D; ext_lines = 16'h2000; step();
        expect_out(1, 'h4D, "R5 equal not blocked");

        // R6 disable
        int_en = 0; step();
        expect_out(0, 0, "R6 withdraw");
        step();
        expect_out(0, 0, "R6 stays idle");
        int_en = 1; step();
        expect_out(1, 'h4D, "R6 re-enable");

        // R8 reset mid-operation
        trap_lvl = 0;
        rst_n = 0; #1;
        expect_out(0, 0, "R8 async reset");
        step(); rst_n = 1; step(); step();
        expect_out(1, 'h4D, "R8 after reset");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule